// File: doc/BRIEF.md
# Replaying Circular Transmit FIFO

This block is the transmit word queue that sits in front of a serial shift engine. Software pushes words in through a valid/ready push port. The shift engine takes words from a valid/ready pop port and reports when it has nothing in flight. With the loop mode off, the queue is an ordinary first-in first-out buffer, and each word is sent once.

When the loop mode is switched on, the queue keeps a shadow copy of its read position as it was at the moment of switching. Words drain in the normal way. Once the queue has run dry and the engine reports idle, the read position jumps back to the shadow copy. The same words then appear at the pop port again. This repeats for as long as the mode stays on, so a fixed pattern can be sent again and again with no further software writes. Words pushed while the mode is on join the repeated set, because the write position is never moved back.

Top module: `loop_txfifo`

## Requirements
- R1: After reset, `level` is 0, `pop_valid` is 0, `push_ready` is 1, `overflow` is 0 and the loop mode is inactive.
- R2: A push is accepted on a clock edge where `push_valid` and `push_ready` are both 1. A pop is accepted on an edge where `pop_valid` and `pop_ready` are both 1. `pop_data` always shows the oldest unpopped word, so words leave in the order they were accepted.
- R3: `level` equals the accepted pushes minus the accepted pops (restores aside). `pop_valid` is 1 exactly when `level` is nonzero. With the loop mode inactive, `push_ready` is 0 exactly when `level` equals DEPTH.
- R4: A push offered while `push_ready` is 0 changes neither the contents nor `level`. It sets `overflow`, which then stays 1 until reset.
- R5: With `loop_en` low, an emptied queue stays empty whatever `engine_idle` does.
- R6: On the first clock edge where `loop_en` is sampled 1 after being 0, the current read position is saved, and the loop mode becomes active from the next cycle.
- R7: While the loop mode is active, words drain normally. No restore happens while `engine_idle` is 0, even when the queue is empty.
- R8: When the loop mode is active, the queue is empty, `engine_idle` is 1, and at least one pop has occurred since the save or since the last restore, the read position is set back to the saved one on that edge. In the next cycle, `level` equals the number of words from the saved position to the write position, and `pop_data` shows the first saved word.
- R9: Every later drain-and-idle round replays the same word sequence, for as long as `loop_en` stays 1.
- R10: Words pushed while the loop mode is active are appended to the repeated set. While the mode is active, `push_ready` is 0 when the repeated set already holds DEPTH words, even if the queue currently looks empty.
- R11: A restore never fires on two consecutive edges, and never fires again before a pop has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Loop (replay) mode enable |
| push_valid | input | 1 | Push request |
| push_data | input | WIDTH | Word to push |
| push_ready | output | 1 | Push can be accepted |
| pop_ready | input | 1 | Engine takes the head word |
| pop_valid | output | 1 | Head word is present |
| pop_data | output | WIDTH | Head word |
| engine_idle | input | 1 | Shift engine has nothing in flight |
| level | output | $clog2(DEPTH)+1 | Words currently queued |
| overflow | output | 1 | Sticky: a push was offered while full |

## Verification
Several behaviours are checked by the assertions on every cycle. `level` never exceeds DEPTH, `overflow` never falls, a refused push leaves the write side unchanged, and `pop_valid` rises without a push only right after an idle cycle in loop mode. The assertions also confirm that a restore never repeats back to back. The scenarios are needed for the rest. They show that the replayed words match the saved sequence in content and order over several rounds, and that an appended word joins the replay. They also show that a full repeated set refuses pushes while the queue looks empty, and that a restore waits for the engine to go idle. These scenarios are swept over every starting read offset and every set size of a small queue.

// File: rtl/loop_txfifo_pkg.sv
package loop_txfifo_pkg;
  // Selects how the read pointer advances on the next edge.
  typedef enum logic [1:0] {
    RD_HOLD    = 2'd0,
    RD_STEP    = 2'd1,
    RD_RESTORE = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/loop_txfifo_store.sv
module loop_txfifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // Data storage needs no reset; validity is tracked by the pointers.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/loop_txfifo_shadow.sv
module loop_txfifo_shadow #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop_en,
  input  logic [PW-1:0] rd_ptr,
  output logic          capture,
  output logic          loop_active,
  output logic [PW-1:0] saved_ptr
);
  logic          loop_q, loop_d;
  logic [PW-1:0] saved_q, saved_d;

  always_comb begin
    capture = loop_en & ~loop_q;
    loop_d  = loop_en;
    saved_d = saved_q;
    if (capture) begin
      saved_d = rd_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q  <= 1'b0;
      saved_q <= '0;
    end else begin
      loop_q  <= loop_d;
      saved_q <= saved_d;
    end
  end

  assign loop_active = loop_q;
  assign saved_ptr   = saved_q;

  AST_SAVE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_q) |-> saved_q == $past(rd_ptr)) else $error("save"); // R6
endmodule

// File: rtl/loop_txfifo_ctrl.sv
module loop_txfifo_ctrl
  import loop_txfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic          pop_ready,
  input  logic          engine_idle,
  input  logic          loop_active,
  input  logic          capture,
  input  logic [PW-1:0] saved_ptr,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          push_fire,
  output logic          push_ready,
  output logic          pop_valid,
  output logic [PW-1:0] level,
  output logic          overflow
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          armed_q, armed_d;
  logic          ovf_q, ovf_d;
  logic [PW-1:0] span;
  logic          empty, pop_fire, restore;
  rd_sel_e       rd_sel;

  // Occupancy is derived from the pointers, so a restore updates it at once.
  assign level = wr_q - rd_q;
  assign empty = (level == '0);
  // In loop mode the looped set, counted from the saved pointer, must fit.
  assign span  = loop_active ? (wr_q - saved_ptr) : level;

  always_comb begin
    push_ready = (span != FULL_LVL);
    pop_valid  = ~empty;
    push_fire  = push_valid & push_ready;
    pop_fire   = pop_ready & pop_valid;
    restore    = loop_active & engine_idle & empty & armed_q;

    if (restore)       rd_sel = RD_RESTORE;
    else if (pop_fire) rd_sel = RD_STEP;
    else               rd_sel = RD_HOLD;

    wr_d = push_fire ? wr_q + PW'(1) : wr_q;
    unique case (rd_sel)
      RD_STEP:    rd_d = rd_q + PW'(1);
      RD_RESTORE: rd_d = saved_ptr;
      default:    rd_d = rd_q;
    endcase

    armed_d = armed_q;
    if (capture | restore) armed_d = 1'b0;
    if (pop_fire)          armed_d = 1'b1;

    ovf_d = ovf_q | (push_valid & ~push_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      armed_q <= armed_d;
      ovf_q   <= ovf_d;
    end
  end

  assign wr_ptr   = wr_q;
  assign rd_ptr   = rd_q;
  assign overflow = ovf_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL) else $error("level bound"); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> wr_q == $past(wr_q)) else $error("drop"); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow) else $error("sticky"); // R4
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> !restore) else $error("rearm"); // R11
  AST_LOOP_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active |-> (wr_q - saved_ptr) <= FULL_LVL) else $error("span"); // R10
endmodule

// File: rtl/loop_txfifo.sv
module loop_txfifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_en,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  input  logic             pop_ready,
  output logic             pop_valid,
  output logic [WIDTH-1:0] pop_data,
  input  logic             engine_idle,
  output logic [PW-1:0]    level,
  output logic             overflow
);
  logic [PW-1:0] wr_ptr, rd_ptr, saved_ptr;
  logic          capture, loop_active, push_fire;

  loop_txfifo_shadow #(.PW(PW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .rd_ptr(rd_ptr),
    .capture(capture), .loop_active(loop_active), .saved_ptr(saved_ptr)
  );

  loop_txfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop_ready(pop_ready),
    .engine_idle(engine_idle), .loop_active(loop_active), .capture(capture),
    .saved_ptr(saved_ptr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .push_fire(push_fire), .push_ready(push_ready), .pop_valid(pop_valid),
    .level(level), .overflow(overflow)
  );

  loop_txfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(push_fire), .wr_idx(wr_ptr[AW-1:0]), .wr_data(push_data),
    .rd_idx(rd_ptr[AW-1:0]), .rd_data(pop_data)
  );

  // A queue can only refill without a push through a restore.
  AST_REFILL_ONLY_BY_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pop_valid) && !$past(push_fire)) |-> $past(loop_active && engine_idle))
    else $error("refill"); // R5
  AST_NO_RESTORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_valid && !engine_idle && !push_fire) |=> !pop_valid) else $error("busy"); // R7
endmodule

// File: tb/loop_txfifo_bench.sv
module loop_txfifo_bench;
  localparam int W = 8;
  localparam int D = 4;
  localparam int PW = $clog2(D) + 1;

  logic clk = 1'b0;
  logic rst_n, loop_en, push_valid, pop_ready, engine_idle;
  logic [W-1:0] push_data;
  logic push_ready, pop_valid, overflow;
  logic [W-1:0] pop_data;
  logic [PW-1:0] level;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  loop_txfifo #(.WIDTH(W), .DEPTH(D)) u_loop_txfifo (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .push_valid(push_valid),
    .push_data(push_data), .push_ready(push_ready), .pop_ready(pop_ready),
    .pop_valid(pop_valid), .pop_data(pop_data), .engine_idle(engine_idle),
    .level(level), .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; loop_en = 1'b0; push_valid = 1'b0; pop_ready = 1'b0;
    engine_idle = 1'b0; push_data = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic push(input logic [W-1:0] d);
    push_valid = 1'b1; push_data = d;
    step();
    push_valid = 1'b0;
  endtask

  // Check the head word, then pop it.
  task automatic pop_chk(input string req, input int exp);
    chk(req, int'(pop_valid), 1);
    chk(req, int'(pop_data), exp);
    pop_ready = 1'b1;
    step();
    pop_ready = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 pop_valid", int'(pop_valid), 0);
    chk("R1 push_ready", int'(push_ready), 1);
    chk("R1 overflow", int'(overflow), 0);

    // R2/R3/R4 ordinary FIFO with overflow
    for (int i = 0; i < D; i++) begin
      push(W'(8'h10 + i));
      chk("R3 level", int'(level), i + 1);
    end
    chk("R3 full", int'(push_ready), 0);
    push(8'hEE);
    chk("R4 level kept", int'(level), D);
    chk("R4 overflow", int'(overflow), 1);
    for (int i = 0; i < D; i++) pop_chk("R2 order", 8'h10 + i);
    chk("R4 sticky", int'(overflow), 1);
    chk("R3 empty", int'(pop_valid), 0);
    // R5 no replay when loop disabled
    engine_idle = 1'b1;
    step(); step(); step();
    chk("R5 stays empty", int'(level), 0);
    engine_idle = 1'b0;

    // Sweep over starting offset k and looped set size n.
    for (int k = 0; k < D; k++) begin
      for (int n = 1; n <= D; n++) begin
        int tot;
        do_reset();
        for (int j = 0; j < k; j++) begin
          push(8'h55);
          pop_ready = 1'b1; step(); pop_ready = 1'b0;
        end
        loop_en = 1'b1;
        step(); // R6 capture at this edge
        for (int i = 0; i < n; i++) push(W'(k * 16 + i));
        chk("R3 loop level", int'(level), n);
        for (int i = 0; i < n; i++) pop_chk("R7 drain", k * 16 + i);
        step(); step();
        chk("R7 no restore busy", int'(pop_valid), 0);
        chk("R10 loop full", int'(push_ready), (n == D) ? 0 : 1);
        engine_idle = 1'b1;
        step();
        chk("R8 restore level", int'(level), n);
        chk("R8 first word", int'(pop_data), k * 16);
        step();
        chk("R11 level held", int'(level), n);
        engine_idle = 1'b0;
        tot = n;
        if (n < D) begin
          push(W'(8'hA0 + k));
          tot = n + 1;
          chk("R10 appended", int'(level), tot);
        end
        for (int r = 0; r < 2; r++) begin
          for (int i = 0; i < tot; i++)
            pop_chk("R9 replay", (i < n) ? (k * 16 + i) : (8'hA0 + k));
          engine_idle = 1'b1;
          step();
          chk("R9 round level", int'(level), tot);
          engine_idle = 1'b0;
        end
        loop_en = 1'b0;
        step();
        for (int i = 0; i < tot; i++) pop_chk("R5 final", (i < n) ? (k * 16 + i) : (8'hA0 + k));
        engine_idle = 1'b1;
        step(); step();
        chk("R5 no replay off", int'(level), 0);
        engine_idle = 1'b0;
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule